// File: doc/BRIEF.md
# Serial Link Signal Detect Monitor

This block watches a recovered serial bitstream, one bit per clock when a valid strobe is high, and judges whether the link carries legal 8B/10B traffic. Its output is a preliminary signal-detect flag. The flag needs three things. The first is an amplitude-valid indication from an analog stage, which is used only when the channel is built with amplitude gating. The second is the absence of any run of identical bits longer than legal line code allows. The third is the presence of the negative-disparity comma somewhere inside each reference-clock window.

Time is divided into windows of a parameterised number of reference ticks, 65536 by default. The block remembers two things over each window: whether a comma was matched and whether a run-length fault occurred. At each window boundary it sets the detect state from that record. A fault pulls detect low at once, and detect stays low until a later boundary clears it. A window without a comma leaves detect low for the whole of the following window. Software-visible status is limited to the two per-window flags.

Top module: `sig_detect_monitor`

## Requirements
- R1: While reset is low and on the first cycle after it is released, sigDetect, runFault and commaFound are all 0.
- R2: The 10-bit sequence 0,0,1,1,1,1,1,0,1,0 (first received bit leftmost) is matched at any bit alignment among valid bits, provided at least ten valid bits have arrived since reset. commaFound is 1 from the cycle after the completing bit until the window ends.
- R3: A valid bit that makes a run of more than five identical valid bits sets runFault and clears the detect state, both visible on the next cycle.
- R4: A run of exactly five identical valid bits raises no fault.
- R5: Cycles with bitValid low do not shift the comma matcher and do not extend or break a run.
- R6: A window ends on the WINDOW_TICKS-th refTick pulse. At that edge the detect state becomes 1 if a comma was matched and no fault occurred during the window, the final cycle included, and becomes 0 otherwise.
- R7: If a window passes without a comma, sigDetect stays 0 for the whole following window.
- R8: The detect state rises only at a window boundary, so after reset it is 0 until one clean window has completed.
- R9: When USE_AMPLITUDE is 1, sigDetect is the detect state ANDed with ampValid, combinationally. When USE_AMPLITUDE is 0, ampValid is ignored.
- R10: At each window boundary commaFound and runFault are cleared, unless an event arrives after that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | serialBit carries a recovered bit this cycle |
| serialBit | input | 1 | Recovered serial data bit |
| refTick | input | 1 | One-cycle pulse per reference clock period |
| ampValid | input | 1 | Analog amplitude is adequate |
| sigDetect | output | 1 | Preliminary signal detect |
| runFault | output | 1 | Run-length fault seen in the current window |
| commaFound | output | 1 | Comma matched in the current window |

## Verification
Four properties are checked on every cycle. A run fault must pull the detect state low on the next cycle. The detect state may rise only just after a boundary. Both flags must read zero after a boundary. Amplitude loss must mask the output. The bench scenarios cover the behaviours no single-cycle property can see. These include comma matching at shifted alignments, the exact five-bit run limit, invalid-bit cycles that are ignored, and the rule that detect stays low for a full window after a window without a comma. A behavioural reference model is compared against every output on every clock.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef struct packed {
    logic commaHit;
    logic runViol;
  } dpEvt_t;
endpackage

// File: rtl/sdm_datapath.sv
module sdm_datapath #(
  parameter int DATA_W = 10,
  parameter logic [DATA_W-1:0] COMMA = 10'b0011111010,
  parameter int MAX_RUN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic serialBit,
  output sdm_pkg::dpEvt_t evt
);
  localparam int RUN_W  = $clog2(MAX_RUN + 2);
  localparam int FILL_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftReg, nextShift;
  logic [FILL_W-1:0] fillCnt;
  logic [RUN_W-1:0]  runLen, nextRun;
  logic              lastBit, sameBit;

  assign nextShift = {shiftReg[DATA_W-2:0], serialBit};
  assign sameBit   = (fillCnt != '0) && (serialBit == lastBit);

  always_comb begin
    if (!sameBit)                              nextRun = RUN_W'(1);
    else if (runLen == RUN_W'(MAX_RUN + 1))    nextRun = runLen;
    else                                       nextRun = runLen + RUN_W'(1);
  end

  always_comb begin
    evt.commaHit = bitValid && (fillCnt >= FILL_W'(DATA_W - 1)) && (nextShift == COMMA);
    evt.runViol  = bitValid && (nextRun > RUN_W'(MAX_RUN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      fillCnt  <= '0;
      runLen   <= '0;
      lastBit  <= 1'b0;
    end else if (bitValid) begin
      shiftReg <= nextShift;
      lastBit  <= serialBit;
      runLen   <= nextRun;
      if (fillCnt != FILL_W'(DATA_W)) fillCnt <= fillCnt + FILL_W'(1);
    end
  end

  // R3: a violation can only come from a bit repeating the previous one
  a_r3_viol_same_bit: assert property (@(posedge clk) disable iff (!rstN)
    evt.runViol |-> (serialBit == lastBit));
endmodule

// File: rtl/sdm_control.sv
module sdm_control #(
  parameter int WINDOW_TICKS = 65536
) (
  input  logic clk,
  input  logic rstN,
  input  logic refTick,
  input  sdm_pkg::dpEvt_t evt,
  output logic detOk,
  output logic commaFound,
  output logic runFault
);
  localparam int CNT_W = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;

  logic [CNT_W-1:0] winCnt;
  logic             winEnd;

  assign winEnd = refTick && (winCnt == CNT_W'(WINDOW_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt     <= '0;
      detOk      <= 1'b0;
      commaFound <= 1'b0;
      runFault   <= 1'b0;
    end else begin
      if (refTick) winCnt <= winEnd ? '0 : winCnt + CNT_W'(1);
      if (winEnd) begin
        detOk      <= (commaFound || evt.commaHit) && !(runFault || evt.runViol);
        commaFound <= 1'b0;
        runFault   <= 1'b0;
      end else begin
        if (evt.commaHit) commaFound <= 1'b1;
        if (evt.runViol) begin
          runFault <= 1'b1;
          detOk    <= 1'b0;
        end
      end
    end
  end

  // R3: a fault drops detect on the following cycle
  a_r3_fault_drops: assert property (@(posedge clk) disable iff (!rstN)
    evt.runViol |=> !detOk);
  // R8: detect rises only right after a boundary
  a_r8_rise_at_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detOk) |-> $past(winEnd));
  // R10: flags read zero after a boundary
  a_r10_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |=> (!commaFound && !runFault));
endmodule

// File: rtl/sig_detect_monitor.sv
module sig_detect_monitor #(
  parameter int WINDOW_TICKS  = 65536,
  parameter int MAX_RUN       = 5,
  parameter bit USE_AMPLITUDE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic serialBit,
  input  logic refTick,
  input  logic ampValid,
  output logic sigDetect,
  output logic runFault,
  output logic commaFound
);
  sdm_pkg::dpEvt_t evt;
  logic detOk;

  sdm_datapath #(.DATA_W(10), .COMMA(10'b0011111010), .MAX_RUN(MAX_RUN)) uDp (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .serialBit(serialBit), .evt(evt));

  sdm_control #(.WINDOW_TICKS(WINDOW_TICKS)) uCtl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .evt(evt),
    .detOk(detOk), .commaFound(commaFound), .runFault(runFault));

  generate
    if (USE_AMPLITUDE) begin : gAmp
      assign sigDetect = detOk && ampValid;
    end else begin : gNoAmp
      assign sigDetect = detOk;
    end
  endgenerate

  // R9: amplitude loss masks the output
  a_r9_amp_mask: assert property (@(posedge clk) disable iff (!rstN)
    (USE_AMPLITUDE && !ampValid) |-> !sigDetect);
endmodule

// File: tb/tb_sig_detect_monitor.sv
module tb_sig_detect_monitor;
  localparam int W = 16;
  logic clk = 1'b0, rstN = 1'b0, bitValid = 1'b0, serialBit = 1'b0;
  logic refTick = 1'b0, ampValid = 1'b1, tickEn = 1'b0, phase = 1'b0;
  logic sigDetect, runFault, commaFound;
  int tests = 0, fails = 0, cyc = 0;

  bit mBits[$];
  int mRun = 0, mCnt = 0;
  bit mLast = 0, mHave = 0, mComma = 0, mFault = 0, mDet = 0;

  sig_detect_monitor #(.WINDOW_TICKS(W), .MAX_RUN(5), .USE_AMPLITUDE(1'b1)) dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .serialBit(serialBit),
    .refTick(refTick), .ampValid(ampValid), .sigDetect(sigDetect),
    .runFault(runFault), .commaFound(commaFound));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    phase   <= ~phase;
    refTick <= tickEn && phase;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      check(1'b0, "watchdog", cyc, 50000);
      summary();
    end
  end

  // behavioural reference model, compared every clock
  always @(posedge clk) begin
    bit hit, viol, wend;
    int v;
    hit = 0; viol = 0;
    if (!rstN) begin
      mBits = {}; mRun = 0; mCnt = 0; mHave = 0; mLast = 0;
      mComma = 0; mFault = 0; mDet = 0;
    end else begin
      if (bitValid) begin
        mBits.push_back(serialBit);
        if (mBits.size() > 10) void'(mBits.pop_front());
        if (mBits.size() == 10) begin
          v = 0;
          foreach (mBits[i]) v = v * 2 + int'(mBits[i]);
          hit = (v == 'h0FA);
        end
        if (mHave && serialBit == mLast) mRun++; else mRun = 1;
        mLast = serialBit; mHave = 1;
        viol = (mRun > 5);
      end
      wend = refTick && (mCnt == W - 1);
      if (refTick) mCnt = wend ? 0 : mCnt + 1;
      if (wend) begin
        mDet = (mComma || hit) && !(mFault || viol);
        mComma = 0; mFault = 0;
      end else begin
        if (hit) mComma = 1;
        if (viol) begin mFault = 1; mDet = 0; end
      end
    end
    #1;
    if (rstN) begin
      check(sigDetect === (mDet && ampValid), "R6 R7 R8 R9 sigDetect", sigDetect, mDet && ampValid);
      check(runFault === mFault, "R3 R4 R5 runFault", runFault, mFault);
      check(commaFound === mComma, "R2 R10 commaFound", commaFound, mComma);
    end
  end

  task automatic sendBit(input bit b, input bit vld = 1'b1);
    @(negedge clk);
    bitValid = vld; serialBit = b;
  endtask

  task automatic sendWord(input logic [9:0] w);
    for (int i = 9; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic settle();
    @(negedge clk);
    bitValid = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    check(sigDetect === 1'b0 && runFault === 1'b0 && commaFound === 1'b0, "R1 reset", sigDetect, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    check(sigDetect === 1'b0 && runFault === 1'b0 && commaFound === 1'b0, "R1 after release", runFault, 0);

    // R2 R6: commas at an offset alignment qualify the link
    tickEn = 1'b1;
    sendBit(1'b1);
    for (int k = 0; k < 6; k++) begin
      sendWord(10'b0011111010);
      sendWord(10'b1100000101);
    end
    settle();
    check(commaFound === 1'b1 || mCnt == 0, "R2 comma matched", commaFound, 1);
    check(sigDetect === 1'b1, "R6 detect after clean window", sigDetect, 1);

    // R9: amplitude masks output
    @(negedge clk); ampValid = 1'b0;
    @(posedge clk); #1;
    check(sigDetect === 1'b0, "R9 amplitude mask", sigDetect, 0);
    @(negedge clk); ampValid = 1'b1;

    // R5 R4 R3 with window frozen
    tickEn = 1'b0;
    repeat (3) @(negedge clk);
    sendWord(10'b0011111010);
    for (int k = 0; k < 3; k++) sendBit(1'b1);
    for (int k = 0; k < 8; k++) sendBit(1'b1, 1'b0);
    for (int k = 0; k < 2; k++) sendBit(1'b1);
    sendBit(1'b0);
    settle();
    check(runFault === 1'b0, "R5 invalid bits ignored", runFault, 0);
    for (int k = 0; k < 5; k++) sendBit(1'b1);
    sendBit(1'b0);
    settle();
    check(runFault === 1'b0, "R4 run of five legal", runFault, 0);
    for (int k = 0; k < 6; k++) sendBit(1'b1);
    settle();
    check(runFault === 1'b1, "R3 run of six faults", runFault, 1);
    check(sigDetect === 1'b0, "R3 detect dropped", sigDetect, 0);

    // R7 R8: windows without comma, then requalify
    tickEn = 1'b1;
    for (int k = 0; k < 200; k++) sendBit(k[0]);
    sendWord(10'b0011111010);
    settle();
    check(sigDetect === 1'b0, "R7 low after missed comma", sigDetect, 0);
    for (int k = 0; k < 8; k++) begin
      sendWord(10'b0011111010);
      sendWord(10'b1100000101);
    end
    settle();
    check(sigDetect === 1'b1, "R8 requalified at boundary", sigDetect, 1);

    // R10: flags clear at boundary
    sendWord(10'b0011111010);
    do begin
      @(negedge clk); bitValid = 1'b0;
      @(posedge clk); #2;
    end while (mCnt != 0);
    check(commaFound === 1'b0 && runFault === 1'b0, "R10 flags cleared", commaFound, 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule